// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs single read and write cycles on an external asynchronous memory bus. A requester gives one access at a time: a direction, an address, a lane enable for each byte of the data word, write data and a one-hot chip select that has already been decoded. The sequencer drives the address, the active-low lane strobes, the chip select, read enable, write enable and a data-drive enable for the external tri-state buffer. When the access ends it reports completion with a one-cycle pulse. For reads, that pulse comes with the captured data.

The strobe phase lasts for a programmed minimum set by a 3-bit code. A peripheral can stretch it further through a wait input, which is synchronized inside the block. That input has an effect only when the wait feature is enabled. If the next request is the same direction and targets the same chip select, the sequencer accepts it in the last strobe cycle, so chip select stays asserted across back-to-back accesses. Any other request waits until the bus has gone idle.

Top module: `ext_bus_seq`

## Requirements
- R1: While reset is active and after it is released with no request pending, bus_re_no, bus_we_no, every bus_cs_no bit and every bus_bs_no bit are 1, bus_doe_o and done_o are 0, and ready_o is 1.
- R2: In the single clock that follows acceptance (the setup cycle), bus_addr_o equals the request address. bus_bs_no is the inverse of the lane enables. bus_cs_no is the inverse of the one-hot select. bus_re_no and bus_we_no are both still 1.
- R3: With a stretch code n (0..7) and no effective wait, the strobe phase (read or write enable low) lasts exactly n+1 clocks. The access therefore takes n+2 clocks from setup to the end of the strobe.
- R4: With the wait feature enabled, every strobe cycle in which the wait input, delayed through a two-flop synchronizer, is 1 adds one clock to the strobe phase on top of n+1.
- R5: With the wait feature disabled, the wait input has no effect, and the strobe phase is n+1 clocks whatever its value.
- R6: For a read, the data input is captured at the clock edge that ends the last strobe cycle. In the following cycle done_o is 1 for exactly one clock and rdata_o holds the captured word, with lanes that were not enabled forced to zero. bus_doe_o stays 0 for the whole read.
- R7: For a write, bus_doe_o is 1 and bus_dout_o equals the request data from the setup cycle through the last strobe cycle. Write enable is low only within that window, and done_o pulses in the cycle after it.
- R8: A request of the same direction and the same chip select that is pending in the last strobe cycle is accepted there (ready_o is 1). Its setup cycle follows at once, and chip select never goes high between the two accesses.
- R9: A request of a different direction or a different chip select is not accepted before the bus is idle, so every chip select is high for at least one clock between the two accesses.
- R10: Lane i of the data word is bits 8i+7..8i, so lane 1 is the upper byte. A lane enable bit of 1 drives the matching bus_bs_no bit low. At most one chip select is low at any time.
- R11: Read enable and write enable are never low together, and neither is low unless a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW (23) | Access address |
| req_lane_i | input | DW/8 (2) | Byte lane enables, bit 1 = upper byte |
| req_cs_i | input | NCS (4) | One-hot decoded chip select |
| req_wdata_i | input | DW (16) | Write data |
| ready_o | output | 1 | Request accepted at the next edge when req_i is 1 |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW (16) | Captured read data, disabled lanes zero |
| cfg_stretch_i | input | CW (3) | Stretch code n, strobe phase of n+1 clocks |
| cfg_wait_en_i | input | 1 | Wait input enable |
| wait_i | input | 1 | Asynchronous peripheral wait, active high |
| bus_addr_o | output | AW (23) | Bus address |
| bus_re_no | output | 1 | Read enable, active low |
| bus_we_no | output | 1 | Write enable, active low |
| bus_cs_no | output | NCS (4) | Chip selects, active low |
| bus_bs_no | output | DW/8 (2) | Byte lane strobes, active low |
| bus_dout_o | output | DW (16) | Write data to the tri-state buffer |
| bus_doe_o | output | 1 | Data drive enable for the tri-state buffer |
| bus_din_i | input | DW (16) | Data read from the bus |

## Verification
A wrong count in the stretch timer shows in the same access as a strobe that is one or more clocks too long or too short. A fault in the synchronizer depth or in the wait gating shifts that length by the number of wait cycles the bench's own two-flop model sees. A wrong state or a stale latched request shows up by the setup cycle or the first strobe cycle, as a wrong address, lane strobe, chip select or drive enable. A fault in the back-to-back acceptance rule shows within one access pair, as a chip-select gap where none is allowed or a missing gap where one is required. Capture timing or masking faults show in the rdata_o value that comes with the done pulse.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2
  } ebs_state_e;
endpackage

// File: rtl/ebs_sync.sv
module ebs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sq <= '0;
    else         sq <= {sq[STAGES-2:0], d_i};
  end

  assign q_o = sq[STAGES-1];
endmodule

// File: rtl/ebs_timer.sv
module ebs_timer #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] init_i,
  input  logic          run_i,
  input  logic          hold_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  // counter freezes while held, so wait cycles add on top of n+1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (load_i)                         cnt_q <= init_i;
    else if (run_i && !hold_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = run_i && !hold_i && (cnt_q == '0);
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int AW          = 23,
  parameter int DW          = 16,
  parameter int NCS         = 4,
  parameter int CW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW/8-1:0]   req_lane_i,
  input  logic [NCS-1:0]    req_cs_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DW-1:0]     rdata_o,
  input  logic [CW-1:0]     cfg_stretch_i,
  input  logic              cfg_wait_en_i,
  input  logic              wait_i,
  output logic [AW-1:0]     bus_addr_o,
  output logic              bus_re_no,
  output logic              bus_we_no,
  output logic [NCS-1:0]    bus_cs_no,
  output logic [DW/8-1:0]   bus_bs_no,
  output logic [DW-1:0]     bus_dout_o,
  output logic              bus_doe_o,
  input  logic [DW-1:0]     bus_din_i
);
  localparam int NL = DW / 8;

  ebs_state_e          state_q, state_d;
  logic                we_q;
  logic [AW-1:0]       addr_q;
  logic [NL-1:0]       lane_q;
  logic [NCS-1:0]      cs_q;
  logic [DW-1:0]       wdata_q;
  logic [DW-1:0]       rdata_q;
  logic                done_q;
  logic                wait_s;
  logic                wait_eff;
  logic                last;
  logic                same_kind;
  logic                accept;
  logic                active;
  logic [DW-1:0]       lane_mask;

  ebs_sync #(.STAGES(SYNC_STAGES)) u_wait_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (wait_i),
    .q_o    (wait_s)
  );

  assign wait_eff = cfg_wait_en_i && wait_s;

  ebs_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == ST_SETUP),
    .init_i (cfg_stretch_i),
    .run_i  (state_q == ST_STROBE),
    .hold_i (wait_eff),
    .last_o (last)
  );

  generate
    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign lane_mask[8*l +: 8] = {8{lane_q[l]}};
    end
  endgenerate

  // chaining only keeps chip select when direction and target match
  assign same_kind = (req_we_i == we_q) && (req_cs_i == cs_q);
  assign ready_o   = (state_q == ST_IDLE) || (last && same_kind);
  assign accept    = req_i && ready_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_STROBE;
      ST_STROBE: if (last) state_d = accept ? ST_SETUP : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      lane_q  <= '0;
      cs_q    <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        we_q    <= req_we_i;
        addr_q  <= req_addr_i;
        lane_q  <= req_lane_i;
        cs_q    <= req_cs_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last;
      if (last && !we_q) rdata_q <= bus_din_i & lane_mask;
    end
  end

  assign active     = (state_q != ST_IDLE);
  assign bus_addr_o = addr_q;
  assign bus_cs_no  = active ? ~cs_q : '1;
  assign bus_bs_no  = active ? ~lane_q : '1;
  assign bus_re_no  = !((state_q == ST_STROBE) && !we_q);
  assign bus_we_no  = !((state_q == ST_STROBE) && we_q);
  assign bus_doe_o  = active && we_q;
  assign bus_dout_o = wdata_q;
  assign done_o     = done_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/ebs_checker.sv
module ebs_checker #(
  parameter int AW  = 23,
  parameter int NCS = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           bus_re_no,
  input logic           bus_we_no,
  input logic [NCS-1:0] bus_cs_no,
  input logic           bus_doe_o,
  input logic [AW-1:0]  bus_addr_o,
  input logic           done_o
);
  logic strb;
  assign strb = !bus_re_no || !bus_we_no;

  a_r11_re_we_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!bus_re_no && !bus_we_no));

  a_r11_strobe_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb |-> (bus_cs_no != '1));

  a_r10_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~bus_cs_no));

  a_r7_we_with_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_we_no |-> bus_doe_o);

  a_r6_read_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_re_no |-> !bus_doe_o);

  a_r6_done_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(strb));

  a_r2_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb && $past(strb)) |-> $stable(bus_addr_o));
endmodule

bind ext_bus_seq ebs_checker #(.AW(AW), .NCS(NCS)) u_ebs_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_re_no  (bus_re_no),
  .bus_we_no  (bus_we_no),
  .bus_cs_no  (bus_cs_no),
  .bus_doe_o  (bus_doe_o),
  .bus_addr_o (bus_addr_o),
  .done_o     (done_o)
);

// File: tb/ext_bus_seq_test.sv
module ext_bus_seq_test;
  localparam int AW = 23, DW = 16, NCS = 4, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_lane = '0;
  logic [NCS-1:0] req_cs = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ready, done;
  logic [DW-1:0] rdata;
  logic [CW-1:0] cfg_stretch = '0;
  logic cfg_wait_en = 1'b0;
  logic wait_in = 1'b0;
  logic [AW-1:0] bus_addr;
  logic re_n, we_n, doe;
  logic [NCS-1:0] cs_n;
  logic [1:0] bs_n;
  logic [DW-1:0] dout, din;

  int checks = 0, errors = 0;
  int wait_mode = 0;
  logic ws1 = 1'b0, ws2 = 1'b0;
  logic e_we;
  logic [AW-1:0] e_addr;
  logic [1:0] e_lane;
  logic [NCS-1:0] e_cs;
  logic [DW-1:0] e_wd;
  int slen = 0, wcnt = 0;
  logic strb_prev = 1'b0;
  logic track_gap = 1'b0;
  int gap = 0;

  always #4 clk = ~clk;

  ext_bus_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_lane_i(req_lane), .req_cs_i(req_cs),
    .req_wdata_i(req_wdata), .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .cfg_stretch_i(cfg_stretch), .cfg_wait_en_i(cfg_wait_en), .wait_i(wait_in),
    .bus_addr_o(bus_addr), .bus_re_no(re_n), .bus_we_no(we_n), .bus_cs_no(cs_n),
    .bus_bs_no(bs_n), .bus_dout_o(dout), .bus_doe_o(doe), .bus_din_i(din)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] + 8'h3C};
  endfunction

  function automatic logic [DW-1:0] lmask(input logic [1:0] l);
    return {{8{l[1]}}, {8{l[0]}}};
  endfunction

  assign din = pat(bus_addr);

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // bench model of the two-flop wait synchronizer
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin ws1 <= 1'b0; ws2 <= 1'b0; end
    else begin ws1 <= wait_in; ws2 <= ws1; end

  always @(negedge clk)
    case (wait_mode)
      0: wait_in <= 1'b0;
      1: wait_in <= 1'b1;
      default: wait_in <= ($urandom % 3) == 0;
    endcase

  // strobe-phase monitor
  always @(negedge clk) begin
    logic strb;
    strb = !re_n || !we_n;
    if (rst_n) begin
      if (strb) begin
        slen++;
        if (cfg_wait_en && ws2) wcnt++;
        chk(bus_addr == e_addr, "R2", "strobe addr", 32'(bus_addr), 32'(e_addr));
        chk(bs_n == ~e_lane, "R10", "lane strobes", 32'(bs_n), 32'(~e_lane));
        chk(cs_n == ~e_cs, "R10", "chip select", 32'(cs_n), 32'(~e_cs));
        chk(doe == e_we, "R7", "drive enable", 32'(doe), 32'(e_we));
        chk(re_n == e_we && we_n == !e_we, "R11", "strobe kind",
            {30'd0, re_n, we_n}, {30'd0, e_we, !e_we});
        if (e_we) chk(dout == e_wd, "R7", "write data", 32'(dout), 32'(e_wd));
      end
      if (strb_prev && !strb) begin
        if (cfg_wait_en)
          chk(slen == cfg_stretch + 1 + wcnt, "R4", "strobe length with wait",
              slen, cfg_stretch + 1 + wcnt);
        else
          chk(slen == cfg_stretch + 1, "R3 R5", "strobe length", slen, cfg_stretch + 1);
        slen = 0;
        wcnt = 0;
      end
      if (done && !e_we)
        chk(rdata == (pat(e_addr) & lmask(e_lane)), "R6", "read data",
            32'(rdata), 32'(pat(e_addr) & lmask(e_lane)));
      if (track_gap && cs_n == '1) gap++;
    end
    strb_prev = strb;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic drive(input logic we, input logic [AW-1:0] a, input logic [1:0] l,
                       input logic [NCS-1:0] cs, input logic [DW-1:0] wd);
    req = 1'b1; req_we = we; req_addr = a; req_lane = l; req_cs = cs; req_wdata = wd;
  endtask

  // waits for acceptance, then checks the setup cycle (R2)
  task automatic accept_setup();
    while (!ready) step();
    step();
    e_we = req_we; e_addr = req_addr; e_lane = req_lane; e_cs = req_cs; e_wd = req_wdata;
    chk(bus_addr == e_addr, "R2", "setup addr", 32'(bus_addr), 32'(e_addr));
    chk(cs_n == ~e_cs && bs_n == ~e_lane, "R2", "setup cs/lanes",
        {26'd0, cs_n, bs_n}, {26'd0, ~e_cs, ~e_lane});
    chk(re_n && we_n, "R2", "setup enables high", {30'd0, re_n, we_n}, 32'd3);
    chk(doe == e_we, "R7", "setup drive", 32'(doe), 32'(e_we));
  endtask

  task automatic wait_done();
    int c = 0;
    while (!done && c < 64) begin step(); c++; end
    chk(done, "R6", "done pulse seen", 32'(done), 32'd1);
  endtask

  task automatic single(input logic we, input logic [AW-1:0] a, input logic [1:0] l,
                        input logic [NCS-1:0] cs, input logic [DW-1:0] wd);
    drive(we, a, l, cs, wd);
    accept_setup();
    req = 1'b0;
    wait_done();
    step();
    chk(!done, "R6", "done one cycle", 32'(done), 32'd0);
  endtask

  task automatic pair(input logic we1, input logic [NCS-1:0] cs1,
                      input logic we2, input logic [NCS-1:0] cs2, input bit hold);
    drive(we1, 23'h001230, 2'b11, cs1, 16'hBEEF);
    accept_setup();
    gap = 0; track_gap = 1'b1;
    drive(we2, 23'h004566, 2'b01, cs2, 16'h1357);
    accept_setup();
    track_gap = 1'b0;
    req = 1'b0;
    if (hold) chk(gap == 0, "R8", "cs held back-to-back", gap, 0);
    else      chk(gap >= 1, "R9", "cs gap on change", gap, 1);
    wait_done();
    step();
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(re_n && we_n && cs_n == '1 && bs_n == '1 && !doe && !done, "R1",
        "in reset", {24'd0, re_n, we_n, cs_n, bs_n}, 32'hFF);
    rst_n = 1'b1;
    step();
    chk(re_n && we_n && cs_n == '1 && bs_n == '1 && !doe && !done && ready, "R1",
        "after reset", {24'd0, re_n, we_n, cs_n, bs_n}, 32'hFF);

    // directed: stretch extremes, lanes
    cfg_stretch = 3'd0; single(1'b0, 23'h000801, 2'b01, 4'b0001, 16'h0);
    cfg_stretch = 3'd7; single(1'b1, 23'h400000, 2'b10, 4'b1000, 16'hA55A);
    cfg_stretch = 3'd3; single(1'b0, 23'h200AB4, 2'b10, 4'b0100, 16'h0);
    cfg_stretch = 3'd1; single(1'b0, 23'h1FFFFE, 2'b11, 4'b0010, 16'h0);

    // R4: wait enabled and held high
    cfg_wait_en = 1'b1; cfg_stretch = 3'd2; wait_mode = 1;
    drive(1'b0, 23'h003456, 2'b11, 4'b0001, 16'h0);
    accept_setup(); req = 1'b0;
    repeat (5) step();
    wait_mode = 0;
    wait_done(); step();

    // R5: wait disabled, input held high
    cfg_wait_en = 1'b0; wait_mode = 1;
    single(1'b1, 23'h00ABCD, 2'b11, 4'b0100, 16'h6789);
    wait_mode = 0;

    // R8 / R9
    cfg_stretch = 3'd1;
    pair(1'b0, 4'b0010, 1'b0, 4'b0010, 1'b1);
    pair(1'b1, 4'b0001, 1'b1, 4'b0001, 1'b1);
    pair(1'b0, 4'b0100, 1'b1, 4'b0100, 1'b0);
    pair(1'b1, 4'b1000, 1'b1, 4'b0001, 1'b0);

    // random traffic with random wait
    wait_mode = 2;
    for (int i = 0; i < 200; i++) begin
      cfg_stretch = CW'($urandom % 8);
      cfg_wait_en = ($urandom % 2) == 1;
      single(($urandom % 2) == 1, AW'($urandom), 2'(1 + ($urandom % 3)),
             NCS'(1 << ($urandom % 4)), DW'($urandom));
    end
    wait_mode = 0;
    repeat (4) step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3 watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule